// File: doc/BRIEF.md
# Parallel Flash Command Interface Controller

This block models the device side of a small byte-wide parallel flash part. The host drives an address bus, a bidirectional byte data bus and three active-low strobes: chip enable, output enable and write enable. On each clock the controller samples the strobes and sorts the bus state into one of four modes: read, write, standby, or a non-writing inhibit state. It drives the data bus only in read mode. In every other mode it leaves the bus at high impedance.

Each completed write cycle is passed to a command decoder. The decoder expects fixed unlock codes at two fixed addresses. A program command is three command writes followed by one target address and data write. A whole-array erase is a six-write sequence. When a sequence completes, the controller starts a timed internal operation on a small register array. While that operation runs, the controller ignores every further write. Reads during that time return a status byte instead of array data: bit 7 is the complement of the bit-7 value being written, and bit 6 changes state after each read cycle. Once the operation finishes, reads return the array contents again.

Top module: `flash_ctrl`

## Requirements
- R1: With ce_ni=0, oe_ni=0, we_ni=1 and no operation running, data_io is driven with the array byte at index addr_i[IDX_W-1:0]. After reset every array byte reads FFh.
- R2: With ce_ni=1, or with ce_ni=0, oe_ni=1, we_ni=1, the controller does not drive data_io.
- R3: A write cycle exists only while ce_ni=0, oe_ni=1 and we_ni=0. Strobe patterns with oe_ni=0 and we_ni=0 do not advance a command sequence and do not change the array.
- R4: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by D@A program array index A. When the operation finishes, that byte holds its old value AND D.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h set every array byte to FFh.
- R6: The internal operation starts when the final write cycle of a sequence ends. That happens when either we_ni or ce_ni rises, whichever comes first. A read begun right after ce_ni rises with we_ni still low already returns status.
- R7: A write that does not match the next expected address and data returns the decoder to idle without touching the array. A correct sequence issued afterwards is accepted.
- R8: While busy, a read returns status: bit 7 = complement of the data bit 7 being written (0 for erase), bit 6 = a toggle that is 0 at start and inverts after each completed read cycle, bits 5:0 = 0.
- R9: Any write issued while busy, including a complete command sequence, is ignored.
- R10: The busy period lasts exactly PROG_CYCLES clocks for program and ERASE_CYCLES clocks for erase. It is counted from the clock edge that ends the final write.
- R11: After completion, a read of the target location returns the true array data. Its bit 7 equals the programmed bit 7 when the cell was erased.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Byte address |
| data_io | inout | 8 | Bidirectional data bus, tristate |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |

## Verification
The bench programs every location of a 16-byte array with a distinct arithmetic pattern. It then reprograms one byte with a partial mask, which separates an AND update from a plain overwrite. Broken sequences are tried at every stage: a wrong unlock address, a wrong command code, and a wrong final erase address. Each is followed by a valid sequence, which shows that the decoder resets instead of latching a stale state. Inhibited strobe patterns and writes issued while busy must leave the array intact. Status reads are timed to the clock just before and just after completion, which pins down the busy length for both operations. One sequence ends on chip enable rather than write enable, to show that either edge starts the operation.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [1:0] {
    BUS_STANDBY,
    BUS_READ,
    BUS_WRITE,
    BUS_INHIBIT
  } bus_mode_e;

  typedef enum logic {
    OP_PROG,
    OP_ERASE
  } flash_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PROG,
    S_ERA1,
    S_ERA2,
    S_ERA3
  } seq_state_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_CODE_A = 8'hAA;
  localparam logic [7:0]  KEY_CODE_B = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERASE = 8'h80;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output bus_mode_e     mode_o,
  output logic          wr_end_o,
  output logic          rd_end_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);

  logic wr_act, rd_act;
  logic wr_q, rd_q;

  assign wr_act = !ce_ni && oe_ni && !we_ni;
  assign rd_act = !ce_ni && !oe_ni && we_ni;

  always_comb begin
    if (ce_ni)       mode_o = BUS_STANDBY;
    else if (rd_act) mode_o = BUS_READ;
    else if (wr_act) mode_o = BUS_WRITE;
    else             mode_o = BUS_INHIBIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      // hold the last values seen while the write strobe was active
      if (wr_act) begin
        wr_addr_o <= addr_i;
        wr_data_o <= wdata_i;
      end
    end
  end

  // first edge of either ce_ni or we_ni closes the write cycle
  assign wr_end_o = wr_q && !wr_act;
  assign rd_end_o = rd_q && !rd_act;

  // R3
  wr_end_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_end_o |-> $past(mode_o) == BUS_WRITE);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_end_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             busy_i,
  output logic             launch_o,
  output flash_op_e        op_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output logic [7:0]       tgt_data_o
);

  localparam logic [AW-1:0] ADDR_A = AW'(KEY_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(KEY_ADDR_B);

  seq_state_e st_q, st_d;
  logic hit_a_key, hit_b_key, hit_prog, hit_erase, hit_chip;

  assign hit_a_key = (wr_addr_i == ADDR_A) && (wr_data_i == KEY_CODE_A);
  assign hit_b_key = (wr_addr_i == ADDR_B) && (wr_data_i == KEY_CODE_B);
  assign hit_prog  = (wr_addr_i == ADDR_A) && (wr_data_i == CODE_PROG);
  assign hit_erase = (wr_addr_i == ADDR_A) && (wr_data_i == CODE_ERASE);
  assign hit_chip  = (wr_addr_i == ADDR_A) && (wr_data_i == CODE_CHIP);

  always_comb begin
    st_d     = st_q;
    launch_o = 1'b0;
    op_o     = OP_PROG;
    if (wr_end_i && !busy_i) begin
      unique case (st_q)
        S_IDLE: st_d = hit_a_key ? S_UNL1 : S_IDLE;
        S_UNL1: st_d = hit_b_key ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          if (hit_prog)       st_d = S_PROG;
          else if (hit_erase) st_d = S_ERA1;
          else                st_d = S_IDLE;
        end
        S_PROG: begin
          launch_o = 1'b1;
          op_o     = OP_PROG;
          st_d     = S_IDLE;
        end
        S_ERA1: st_d = hit_a_key ? S_ERA2 : S_IDLE;
        S_ERA2: st_d = hit_b_key ? S_ERA3 : S_IDLE;
        S_ERA3: begin
          launch_o = hit_chip;
          op_o     = OP_ERASE;
          st_d     = S_IDLE;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  assign tgt_idx_o  = wr_addr_i[IDX_W-1:0];
  assign tgt_data_o = wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= S_IDLE;
    else if (busy_i) st_q <= S_IDLE;
    else             st_q <= st_d;
  end

  // R7
  busy_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_end_i && busy_i) |=> (st_q == S_IDLE));

endmodule

// File: rtl/flash_array_engine.sv
module flash_array_engine
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned PROG_CYCLES  = 32,
  parameter int unsigned ERASE_CYCLES = 4096,
  localparam int unsigned IDX_W       = $clog2(DEPTH),
  localparam int unsigned CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  flash_op_e        op_i,
  input  logic [IDX_W-1:0] tgt_idx_i,
  input  logic [7:0]       tgt_data_i,
  input  logic             rd_end_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             busy_o,
  output logic [7:0]       rdata_o
);

  logic [7:0]       mem_q [DEPTH];
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  flash_op_e        op_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       data_q;
  logic             tog_q;
  logic             done;
  logic             poll_bit;

  assign done     = busy_q && (cnt_q == '0);
  assign poll_bit = (op_q == OP_ERASE) ? 1'b0 : ~data_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
      idx_q  <= '0;
      data_q <= '0;
      tog_q  <= 1'b0;
    end else if (launch_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= (op_i == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
      op_q   <= op_i;
      idx_q  <= tgt_idx_i;
      data_q <= tgt_data_i;
      tog_q  <= 1'b0;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q - 1'b1;
      if (rd_end_i) tog_q <= ~tog_q;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= 8'hFF;
      end else if (done) begin
        if (op_q == OP_ERASE)             mem_q[g] <= 8'hFF;
        else if (idx_q == IDX_W'(g))      mem_q[g] <= mem_q[g] & data_q;
      end
    end
  end

  assign busy_o  = busy_q;
  assign rdata_o = busy_q ? {poll_bit, tog_q, 6'b0} : mem_q[rd_idx_i];

  // R9
  no_relaunch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R8
  tog_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_end_i && !launch_i) |=> $stable(tog_q));

  // R5
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && op_q == OP_ERASE) |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned AW           = 16,
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned PROG_CYCLES  = 32,
  parameter int unsigned ERASE_CYCLES = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  inout  wire  [7:0]    data_io,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  bus_mode_e        mode;
  logic             wr_end, rd_end, busy, launch;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data, tgt_data, rdata;
  logic [IDX_W-1:0] tgt_idx;
  flash_op_e        op;

  flash_bus_decode #(.AW(AW)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .we_ni     (we_ni),
    .addr_i    (addr_i),
    .wdata_i   (data_io),
    .mode_o    (mode),
    .wr_end_o  (wr_end),
    .rd_end_o  (rd_end),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  flash_cmd_seq #(.AW(AW), .IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_end_i   (wr_end),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .busy_i     (busy),
    .launch_o   (launch),
    .op_o       (op),
    .tgt_idx_o  (tgt_idx),
    .tgt_data_o (tgt_data)
  );

  flash_array_engine #(
    .DEPTH        (DEPTH),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .op_i       (op),
    .tgt_idx_i  (tgt_idx),
    .tgt_data_i (tgt_data),
    .rd_end_i   (rd_end),
    .rd_idx_i   (addr_i[IDX_W-1:0]),
    .busy_o     (busy),
    .rdata_o    (rdata)
  );

  assign data_io = (mode == BUS_READ) ? rdata : 8'hzz;

endmodule

// File: tb/flash_ctrl_test.sv
`timescale 1ns/1ps
module flash_ctrl_test;

  localparam int AW = 16;
  localparam int DEPTH = 16;
  localparam int PROG = 16;
  localparam int ERASE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic host_en = 1'b0;
  logic [7:0] host_val = '0;
  wire  [7:0] dbus;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  assign dbus = host_en ? host_val : 8'hzz;

  always #4 clk = ~clk;

  flash_ctrl #(.AW(AW), .DEPTH(DEPTH), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_io(dbus),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit ce_first = 0,
                    input bit inhibit = 0);
    @(negedge clk);
    addr = a; host_val = d; host_en = 1'b1; ce_n = 1'b0; oe_n = inhibit ? 1'b0 : 1'b1; we_n = 1'b1;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; host_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); v = dbus; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic prog_seq(input logic [15:0] a, input logic [7:0] d, input bit ce_first = 0,
                          input bit inhibit = 0);
    wr(16'h5555, 8'hAA, 0, inhibit);
    wr(16'h2AAA, 8'h55, 0, inhibit);
    wr(16'h5555, 8'hA0, 0, inhibit);
    wr(a, d, ce_first, inhibit);
  endtask

  task automatic erase_seq();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h10);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(16'(i), v);
      chk(req, v, model[i]);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents
    sweep("R1");

    // R2: bus left to host in standby and output-disable
    host_val = 8'h5A; host_en = 1'b1; ce_n = 1'b1; oe_n = 1'b0; addr = 16'h0002;
    @(negedge clk); chk("R2", dbus, 8'h5A);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk); chk("R2", dbus, 8'h5A);
    ce_n = 1'b1; host_en = 1'b0;

    // R4/R8/R11: program every byte with a pattern
    for (int i = 0; i < DEPTH; i++) begin
      d = 8'(i * 53 + 7);
      prog_seq(16'(i), d);
      if (i == 0) begin
        rd(16'(i), v); chk("R8", v, {~d[7], 1'b0, 6'b0});
        rd(16'(i), v); chk("R8", v, {~d[7], 1'b1, 6'b0});
      end
      wait_cyc(PROG + 2);
      model[i] = model[i] & d;
    end
    sweep("R11");

    // R4: AND semantics
    prog_seq(16'h0003, 8'h0F);
    wait_cyc(PROG + 2);
    model[3] = model[3] & 8'h0F;
    rd(16'h0003, v); chk("R4", v, model[3]);

    // R6: final write closed by chip enable
    prog_seq(16'h0005, 8'h00, 1);
    rd(16'h0005, v); chk("R6", v, 8'h80);
    wait_cyc(PROG + 2);
    model[5] = 8'h00;
    rd(16'h0005, v); chk("R6", v, 8'h00);

    // R7: broken sequences
    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0006, 8'h00);
    wait_cyc(PROG + 2);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h77); wr(16'h0007, 8'h00);
    wait_cyc(PROG + 2);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h4444, 8'h10);
    wait_cyc(ERASE + 2);
    sweep("R7");
    prog_seq(16'h0006, 8'h00);
    wait_cyc(PROG + 2);
    model[6] = 8'h00;
    rd(16'h0006, v); chk("R7", v, 8'h00);

    // R3: inhibited strobes do nothing
    prog_seq(16'h0008, 8'h00, 0, 1);
    wait_cyc(PROG + 2);
    sweep("R3");

    // R5/R8/R9: erase, with reads and a program attempt while busy
    erase_seq();
    rd(16'h0001, v); chk("R8", v, 8'h00);
    rd(16'h0001, v); chk("R8", v, 8'h40);
    prog_seq(16'h0001, 8'h00);
    rd(16'h0001, v); chk("R9", v, 8'h00);
    wait_cyc(ERASE + 2);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    sweep("R5");
    rd(16'h0001, v); chk("R9", v, 8'hFF);

    // R10: exact program duration
    prog_seq(16'h0009, 8'h3C);
    wait_cyc(PROG - 2);
    addr = 16'h0009; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); chk("R10", dbus, 8'h80);
    @(negedge clk); chk("R10", dbus, 8'h3C);
    ce_n = 1'b1; oe_n = 1'b1;
    model[9] = 8'h3C;

    // R10: exact erase duration
    erase_seq();
    wait_cyc(ERASE - 2);
    addr = 16'h0009; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); chk("R10", dbus, 8'h00);
    @(negedge clk); chk("R10", dbus, 8'hFF);
    ce_n = 1'b1; oe_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule